// File: doc/BRIEF.md
# Three-Format Instruction Decoder

A purely combinational decoder for 32-bit fixed-length instructions in the register, immediate and jump formats. From the instruction word alone it slices out the register specifiers, the shift count, the 16-bit constant and the 26-bit jump target. It also produces the control word that drives the register file, the ALU and the next-PC logic.

Operations in the register format are selected by a 6-bit function code under opcode 0. All other operations are selected by the opcode. The destination register comes from the rd field, the rt field or register 31, depending on the instruction. An opcode or function code the block does not recognise raises an illegal flag and removes every write.

Top module: `isa_decoder`

## Requirements
- R1: `rs_o`=bits 25:21, `rt_o`=bits 20:16, `rd_o`=bits 15:11, `shamt_o`=bits 10:6, `imm16_o`=bits 15:0 and `target_o`=bits 25:0 of `instr_i`, for every input.
- R2: `imm_ext_o` zero-extends `imm16_o` for andi (op 12), ori (op 13) and lui (op 15), and sign-extends it for all other instructions.
- R3: With opcode 0, `alu_op_o` is set from the function code with `alu_src_imm_o`=0. The codes are: add (32)→0, sub (34)→1, and (36)→2, or (37)→3, nor (39)→4, slt (42)→5, sll (0)→6, srl (2)→7. jr (8) gives `jump_o`=2 and writes no register.
- R4: `dst_reg_o` is rd for opcode 0, 31 for jal and rt for all other legal instructions. The register-writing instructions are the R-format ALU operations, loads, addi, slti, andi, ori, lui and jal.
- R5: Loads lb/lh/lw (op 32/33/35) assert `mem_re_o`. Stores sb/sh/sw (op 40/41/43) assert `mem_we_o` and write no register. Both select the immediate operand with `alu_op_o`=0. `mem_size_o` is 0 for byte, 1 for halfword and 2 for word, and 0 when there is no memory access.
- R6: beq (op 4) gives `branch_o`=1 and bne (op 5) gives `branch_o`=2. Both use `alu_op_o`=1 with register operands and write nothing. For all other instructions `branch_o`=0.
- R7: j (op 2) gives `jump_o`=1 with no write. jal (op 3) gives `jump_o`=1, `link_o`=1 and writes register 31. For all other instructions `jump_o`=0 (except jr) and `link_o`=0.
- R8: addi (op 8)→`alu_op_o` 0, slti (op 10)→5, andi (op 12)→2, ori (op 13)→3, lui (op 15)→8. Each of these has `alu_src_imm_o`=1.
- R9: Whenever `dst_reg_o` is 0, `reg_we_o` is 0. This includes the all-zero word, which is a legal sll.
- R10: An undefined opcode, or an undefined function code under opcode 0, sets `illegal_o`=1. All other outputs except the R1/R2 fields are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source specifier |
| rt_o | output | 5 | Second source specifier |
| rd_o | output | 5 | R-format destination field |
| shamt_o | output | 5 | Shift count |
| imm16_o | output | 16 | Raw immediate |
| imm_ext_o | output | 32 | Extended immediate |
| target_o | output | 26 | Jump target field |
| reg_we_o | output | 1 | Register-file write enable |
| dst_reg_o | output | 5 | Selected destination register |
| alu_src_imm_o | output | 1 | ALU second operand is the immediate |
| alu_op_o | output | 4 | ALU operation code |
| mem_re_o | output | 1 | Memory read |
| mem_we_o | output | 1 | Memory write |
| mem_size_o | output | 2 | Access size |
| branch_o | output | 2 | Branch type |
| jump_o | output | 2 | Jump type |
| link_o | output | 1 | Return address is written |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
Every result depends only on `instr_i` and is due in the same cycle, with no register between input and output. The bench therefore drives a new word on the rising edge of the clock and compares all outputs at the following falling edge. This gives half a period of settling and never samples at the edge where the input changes. The table covers every opcode and function code, writes to register 0 and two undefined encodings. Directed cases then check the field slicing and both kinds of immediate extension.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned OPW    = 6;
  localparam int unsigned REGW   = 5;
  localparam int unsigned IMMW   = 16;
  localparam int unsigned TGTW   = 26;
  localparam int unsigned ALUW   = 4;
  localparam logic [REGW-1:0] LINK_REG = REGW'(31);

  typedef enum logic [ALUW-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_NOR = 4'd4, ALU_SLT = 4'd5, ALU_SLL = 4'd6, ALU_SRL = 4'd7,
    ALU_LUI = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_kind_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} mem_size_e;
  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2} branch_e;
  typedef enum logic [1:0] {JMP_NONE = 2'd0, JMP_TGT = 2'd1, JMP_REG = 2'd2} jump_e;

  typedef struct packed {
    logic      legal;
    logic      reg_we;
    dst_kind_e dst_kind;
    logic      alu_src_imm;
    alu_op_e   alu_op;
    logic      mem_re;
    logic      mem_we;
    mem_size_e mem_size;
    branch_e   branch;
    jump_e     jump;
    logic      link;
    logic      zero_ext;
  } ctrl_t;

  localparam ctrl_t CTRL_NONE = '{
    legal: 1'b0, reg_we: 1'b0, dst_kind: DST_RT, alu_src_imm: 1'b0,
    alu_op: ALU_ADD, mem_re: 1'b0, mem_we: 1'b0, mem_size: SZ_BYTE,
    branch: BR_NONE, jump: JMP_NONE, link: 1'b0, zero_ext: 1'b0
  };
endpackage

// File: rtl/isa_field_split.sv
module isa_field_split
  import isa_dec_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output logic [OPW-1:0]  op_o,
  output logic [REGW-1:0] rs_o,
  output logic [REGW-1:0] rt_o,
  output logic [REGW-1:0] rd_o,
  output logic [REGW-1:0] shamt_o,
  output logic [OPW-1:0]  funct_o,
  output logic [IMMW-1:0] imm16_o,
  output logic [TGTW-1:0] target_o
);
  localparam int unsigned RS_LO = ILEN - OPW - REGW;
  localparam int unsigned RT_LO = RS_LO - REGW;
  localparam int unsigned RD_LO = RT_LO - REGW;
  localparam int unsigned SH_LO = RD_LO - REGW;

  assign op_o     = instr_i[ILEN-1 -: OPW];
  assign rs_o     = instr_i[RS_LO +: REGW];
  assign rt_o     = instr_i[RT_LO +: REGW];
  assign rd_o     = instr_i[RD_LO +: REGW];
  assign shamt_o  = instr_i[SH_LO +: REGW];
  assign funct_o  = instr_i[OPW-1:0];
  assign imm16_o  = instr_i[IMMW-1:0];
  assign target_o = instr_i[TGTW-1:0];
endmodule

// File: rtl/isa_funct_decode.sv
module isa_funct_decode
  import isa_dec_pkg::*;
(
  input  logic [OPW-1:0] funct_i,
  output ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o = CTRL_NONE;
    ctrl_o.dst_kind = DST_RD;
    unique case (funct_i)
      6'd32: begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
      6'd34: begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      6'd36: begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
      6'd37: begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
      6'd39: begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_NOR; end
      6'd42: begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_SLT; end
      6'd0:  begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_SLL; end
      6'd2:  begin ctrl_o.legal = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_SRL; end
      6'd8:  begin ctrl_o.legal = 1'b1; ctrl_o.jump = JMP_REG; end
      default: ;
    endcase
  end
endmodule

// File: rtl/isa_op_decode.sv
module isa_op_decode
  import isa_dec_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o = CTRL_NONE;
    unique case (op_i)
      6'd4, 6'd5: begin
        ctrl_o.legal  = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
        ctrl_o.branch = (op_i == 6'd4) ? BR_EQ : BR_NE;
      end
      6'd2: begin ctrl_o.legal = 1'b1; ctrl_o.jump = JMP_TGT; end
      6'd3: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.jump     = JMP_TGT;
        ctrl_o.link     = 1'b1;
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.dst_kind = DST_LINK;
      end
      6'd8, 6'd10, 6'd12, 6'd13, 6'd15: begin
        ctrl_o.legal       = 1'b1;
        ctrl_o.reg_we      = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.zero_ext    = (op_i == 6'd12) || (op_i == 6'd13) || (op_i == 6'd15);
        case (op_i)
          6'd10:   ctrl_o.alu_op = ALU_SLT;
          6'd12:   ctrl_o.alu_op = ALU_AND;
          6'd13:   ctrl_o.alu_op = ALU_OR;
          6'd15:   ctrl_o.alu_op = ALU_LUI;
          default: ctrl_o.alu_op = ALU_ADD;
        endcase
      end
      6'd32, 6'd33, 6'd35: begin
        ctrl_o.legal       = 1'b1;
        ctrl_o.reg_we      = 1'b1;
        ctrl_o.mem_re      = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_size    = (op_i == 6'd32) ? SZ_BYTE : (op_i == 6'd33) ? SZ_HALF : SZ_WORD;
      end
      6'd40, 6'd41, 6'd43: begin
        ctrl_o.legal       = 1'b1;
        ctrl_o.mem_we      = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_size    = (op_i == 6'd40) ? SZ_BYTE : (op_i == 6'd41) ? SZ_HALF : SZ_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/isa_decoder.sv
module isa_decoder
  import isa_dec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rs_o,
  output logic [4:0]  rt_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  shamt_o,
  output logic [15:0] imm16_o,
  output logic [31:0] imm_ext_o,
  output logic [25:0] target_o,
  output logic        reg_we_o,
  output logic [4:0]  dst_reg_o,
  output logic        alu_src_imm_o,
  output logic [3:0]  alu_op_o,
  output logic        mem_re_o,
  output logic        mem_we_o,
  output logic [1:0]  mem_size_o,
  output logic [1:0]  branch_o,
  output logic [1:0]  jump_o,
  output logic        link_o,
  output logic        illegal_o
);
  logic [OPW-1:0] op, funct;
  ctrl_t op_ctrl, fn_ctrl, ctrl;
  logic [REGW-1:0] dst_sel;

  isa_field_split u_split (
    .instr_i (instr_i), .op_o (op), .rs_o (rs_o), .rt_o (rt_o), .rd_o (rd_o),
    .shamt_o (shamt_o), .funct_o (funct), .imm16_o (imm16_o), .target_o (target_o)
  );
  isa_op_decode    u_op (.op_i (op),       .ctrl_o (op_ctrl));
  isa_funct_decode u_fn (.funct_i (funct), .ctrl_o (fn_ctrl));

  assign ctrl = (op == '0) ? fn_ctrl : op_ctrl;

  always_comb begin
    unique case (ctrl.dst_kind)
      DST_RD:   dst_sel = rd_o;
      DST_LINK: dst_sel = LINK_REG;
      default:  dst_sel = rt_o;
    endcase
  end

  assign dst_reg_o     = ctrl.legal ? dst_sel : '0;
  // writes to register 0 are dropped
  assign reg_we_o      = ctrl.legal && ctrl.reg_we && (dst_reg_o != '0);
  assign imm_ext_o     = ctrl.zero_ext ? {{(ILEN-IMMW){1'b0}}, imm16_o}
                                       : {{(ILEN-IMMW){imm16_o[IMMW-1]}}, imm16_o};
  assign alu_src_imm_o = ctrl.alu_src_imm;
  assign alu_op_o      = ctrl.alu_op;
  assign mem_re_o      = ctrl.mem_re;
  assign mem_we_o      = ctrl.mem_we;
  assign mem_size_o    = ctrl.mem_size;
  assign branch_o      = ctrl.branch;
  assign jump_o        = ctrl.jump;
  assign link_o        = ctrl.link;
  assign illegal_o     = !ctrl.legal;

  always_comb begin
    // R10
    illegal_no_write_chk: assert (!(illegal_o && (reg_we_o || mem_we_o || mem_re_o)));
    // R9
    zero_dst_no_write_chk: assert (!(reg_we_o && (dst_reg_o == '0)));
    // R7
    link_to_ra_chk: assert (!link_o || (dst_reg_o == LINK_REG && reg_we_o && jump_o == 2'd1));
    // R5
    mem_excl_chk: assert (!(mem_re_o && mem_we_o));
    // R6
    branch_no_jump_chk: assert (!((branch_o != 2'd0) && ((jump_o != 2'd0) || reg_we_o)));
  end
endmodule

// File: tb/isa_decoder_tb_top.sv
module isa_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  rs, rt, rd, shamt, dst;
  logic [15:0] imm16;
  logic [31:0] imm_ext;
  logic [25:0] target;
  logic        reg_we, src_imm, mem_re, mem_we, link, illegal;
  logic [3:0]  alu_op;
  logic [1:0]  mem_size, branch, jump;

  isa_decoder dut_i (
    .instr_i (instr), .rs_o (rs), .rt_o (rt), .rd_o (rd), .shamt_o (shamt),
    .imm16_o (imm16), .imm_ext_o (imm_ext), .target_o (target),
    .reg_we_o (reg_we), .dst_reg_o (dst), .alu_src_imm_o (src_imm),
    .alu_op_o (alu_op), .mem_re_o (mem_re), .mem_we_o (mem_we),
    .mem_size_o (mem_size), .branch_o (branch), .jump_o (jump),
    .link_o (link), .illegal_o (illegal)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [15:0] lo;
    logic        we;
    logic [4:0]  dst;
    logic        src;
    logic [3:0]  alu;
    logic        re;
    logic        mw;
    logic [1:0]  sz;
    logic [1:0]  br;
    logic [1:0]  jp;
    logic        lk;
    logic        il;
  } vec_t;

  localparam int NV = 29;
  // fields: op rs rt lo | we dst src alu re mw sz br jp lk il
  localparam vec_t VECS [NV] = '{
    '{6'd0, 5'd5, 5'd15,16'h8020, 1'b1,5'd16,1'b0,4'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 add
    '{6'd0, 5'd1, 5'd2, 16'h1822, 1'b1,5'd3, 1'b0,4'd1,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 sub
    '{6'd0, 5'd6, 5'd7, 16'h2024, 1'b1,5'd4, 1'b0,4'd2,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 and
    '{6'd0, 5'd6, 5'd7, 16'h2825, 1'b1,5'd5, 1'b0,4'd3,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 or
    '{6'd0, 5'd6, 5'd7, 16'h3027, 1'b1,5'd6, 1'b0,4'd4,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 nor
    '{6'd0, 5'd6, 5'd7, 16'h382A, 1'b1,5'd7, 1'b0,4'd5,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 slt
    '{6'd0, 5'd0, 5'd16,16'h5100, 1'b1,5'd10,1'b0,4'd6,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 sll
    '{6'd0, 5'd0, 5'd16,16'h4882, 1'b1,5'd9, 1'b0,4'd7,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R3 srl
    '{6'd0, 5'd31,5'd0, 16'h0008, 1'b0,5'd0, 1'b0,4'd0,1'b0,1'b0,2'd0,2'd0,2'd2,1'b0,1'b0}, // R3 jr
    '{6'd0, 5'd1, 5'd2, 16'h0020, 1'b0,5'd0, 1'b0,4'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R9 add r0
    '{6'd0, 5'd1, 5'd2, 16'h0801, 1'b0,5'd0, 1'b0,4'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b1}, // R10 funct 1
    '{6'd35,5'd18,5'd8, 16'h0020, 1'b1,5'd8, 1'b1,4'd0,1'b1,1'b0,2'd2,2'd0,2'd0,1'b0,1'b0}, // R5 lw
    '{6'd43,5'd9, 5'd8, 16'h04B0, 1'b0,5'd8, 1'b1,4'd0,1'b0,1'b1,2'd2,2'd0,2'd0,1'b0,1'b0}, // R5 sw
    '{6'd32,5'd9, 5'd10,16'h0004, 1'b1,5'd10,1'b1,4'd0,1'b1,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R5 lb
    '{6'd33,5'd9, 5'd11,16'h0004, 1'b1,5'd11,1'b1,4'd0,1'b1,1'b0,2'd1,2'd0,2'd0,1'b0,1'b0}, // R5 lh
    '{6'd40,5'd9, 5'd12,16'h0004, 1'b0,5'd12,1'b1,4'd0,1'b0,1'b1,2'd0,2'd0,2'd0,1'b0,1'b0}, // R5 sb
    '{6'd41,5'd9, 5'd13,16'h0004, 1'b0,5'd13,1'b1,4'd0,1'b0,1'b1,2'd1,2'd0,2'd0,1'b0,1'b0}, // R5 sh
    '{6'd4, 5'd1, 5'd2, 16'hFFFC, 1'b0,5'd2, 1'b0,4'd1,1'b0,1'b0,2'd0,2'd1,2'd0,1'b0,1'b0}, // R6 beq
    '{6'd5, 5'd1, 5'd2, 16'h0010, 1'b0,5'd2, 1'b0,4'd1,1'b0,1'b0,2'd0,2'd2,2'd0,1'b0,1'b0}, // R6 bne
    '{6'd2, 5'd3, 5'd4, 16'h1234, 1'b0,5'd4, 1'b0,4'd0,1'b0,1'b0,2'd0,2'd0,2'd1,1'b0,1'b0}, // R7 j
    '{6'd3, 5'd0, 5'd0, 16'h0040, 1'b1,5'd31,1'b0,4'd0,1'b0,1'b0,2'd0,2'd0,2'd1,1'b1,1'b0}, // R7 jal
    '{6'd8, 5'd1, 5'd9, 16'h0005, 1'b1,5'd9, 1'b1,4'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R8 addi
    '{6'd10,5'd1, 5'd9, 16'h0005, 1'b1,5'd9, 1'b1,4'd5,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R8 slti
    '{6'd12,5'd1, 5'd9, 16'h0005, 1'b1,5'd9, 1'b1,4'd2,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R8 andi
    '{6'd13,5'd1, 5'd9, 16'h0005, 1'b1,5'd9, 1'b1,4'd3,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R8 ori
    '{6'd15,5'd0, 5'd9, 16'hAAAA, 1'b1,5'd9, 1'b1,4'd8,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R8 lui
    '{6'd8, 5'd1, 5'd0, 16'h0005, 1'b0,5'd0, 1'b1,4'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0}, // R9 addi r0
    '{6'd63,5'd1, 5'd2, 16'h0005, 1'b0,5'd0, 1'b0,4'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b1}, // R10 op 63
    '{6'd35,5'd1, 5'd0, 16'h0008, 1'b0,5'd0, 1'b1,4'd0,1'b1,1'b0,2'd2,2'd0,2'd0,1'b0,1'b0}  // R9 lw r0
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [20:0] ctl_now();
    return {reg_we, dst, src_imm, alu_op, mem_re, mem_we, mem_size, branch, jump, link, illegal};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  initial begin
    instr = 32'h0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state with the all-zero word: legal sll to r0, no write (R9)
    check("R9 zero word", {62'd0, illegal, reg_we}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply({VECS[i].op, VECS[i].rs, VECS[i].rt, VECS[i].lo});
      check($sformatf("R3-R10 table vector %0d", i), {43'd0, ctl_now()},
            {43'd0, VECS[i].we, VECS[i].dst, VECS[i].src, VECS[i].alu, VECS[i].re,
             VECS[i].mw, VECS[i].sz, VECS[i].br, VECS[i].jp, VECS[i].lk, VECS[i].il});
    end

    // R1 field slicing on add $16,$5,$15
    apply(32'h00AF8020);
    check("R1 rs/rt/rd/shamt", {44'd0, rs, rt, rd, shamt}, {44'd0, 5'd5, 5'd15, 5'd16, 5'd0});
    apply({6'd0, 5'd0, 5'd16, 5'd10, 5'd4, 6'd0});
    check("R1 shamt", {59'd0, shamt}, 64'd4);
    apply({6'd2, 26'h2ABCDEF});
    check("R1 target", {38'd0, target}, {38'd0, 26'h2ABCDEF});
    // R2 extension
    apply({6'd8, 5'd1, 5'd2, 16'hFFFC});
    check("R2 addi sign", {32'd0, imm_ext}, {32'd0, 32'hFFFFFFFC});
    check("R1 imm16", {48'd0, imm16}, {48'd0, 16'hFFFC});
    apply({6'd12, 5'd1, 5'd2, 16'hFFFC});
    check("R2 andi zero", {32'd0, imm_ext}, {32'd0, 32'h0000FFFC});
    apply({6'd13, 5'd1, 5'd2, 16'h8001});
    check("R2 ori zero", {32'd0, imm_ext}, {32'd0, 32'h00008001});
    apply({6'd15, 5'd0, 5'd2, 16'h8001});
    check("R2 lui zero", {32'd0, imm_ext}, {32'd0, 32'h00008001});
    apply({6'd35, 5'd1, 5'd2, 16'h8000});
    check("R2 lw sign", {32'd0, imm_ext}, {32'd0, 32'hFFFF8000});
    apply({6'd4, 5'd1, 5'd2, 16'h7FFF});
    check("R2 beq positive", {32'd0, imm_ext}, {32'd0, 32'h00007FFF});
    // R10 undefined funct 63 under op 0 with nonzero rd
    apply({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd63});
    check("R10 funct 63", {62'd0, illegal, reg_we}, 64'd2);
    // R4 jal ignores rt field
    apply({6'd3, 26'h3FFFFFF});
    check("R4 jal dst", {59'd0, dst}, 64'd31);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule